// File: doc/BRIEF.md
# Indexed Extension-Word Address Calculator

This block works out the effective address of an operand that uses an indexed addressing mode with an extension word. The caller pulses `start` and presents four things: the 16-bit extension word, the 6-bit mode/register field, the PC value at the extension word, and the data and address register files. The block first decodes the extension word and forms a base value and a scaled index. Further instruction words, if any, come from a request/valid stream, and they supply the base displacement and the outer displacement. For the memory-indirect selectors the block also issues one 32-bit read. It then pulses `done` for one cycle. With `done` it presents the final address, the number of extension bytes it consumed, and two flags: one for an illegal field combination and one for an aborted calculation. The block leaves the program counter and the operand fetch to its caller.

Both formats are supported. The brief format yields base + 8-bit displacement + index in a single pass. The full format adds several options: the base and the index can each be suppressed, the two displacements can each be null, word or long, and the memory indirection can be pre-indexed or post-indexed.

The controller is one enumerated state machine with these states:
- `ST_IDLE`: waiting for `start`.
- `ST_BD_HI` and `ST_BD_LO`: fetching the base displacement, upper word and then lower word.
- `ST_OD_HI` and `ST_OD_LO`: fetching the outer displacement, upper word and then lower word.
- `ST_IND`: the indirect long read.
- `ST_DONE`: the result cycle.

The transitions are:
- From `ST_IDLE`, on `start`:
  - a brief word goes to `ST_DONE`;
  - an illegal full word goes to `ST_DONE`;
  - otherwise the first needed fetch state is entered. A long displacement enters at its `_HI` state and a word displacement at its `_LO` state.
- `ST_BD_HI` goes to `ST_BD_LO`.
- `ST_BD_LO` goes to the outer-displacement fetch, to `ST_IND`, or to `ST_DONE`, depending on the selector.
- `ST_OD_HI` goes to `ST_OD_LO`.
- `ST_OD_LO` goes to `ST_IND`.
- `ST_IND` goes to `ST_DONE`.
- Any bus error in a fetch state or in `ST_IND` jumps to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `idx_ea_calc`

## Requirements
- R1: When extension bit 8 is 0 (brief format), the address is base + sign-extended bits 7:0 + scaled index. The length is 2 bytes, and no instruction word or memory read is requested.
- R2: The index register is selected as follows:
  - Bit 15 chooses the register file: 1 for an address register, 0 for a data register.
  - Bits 14:12 give the register number.
  - Bit 11 gives the index size: 1 uses the whole 32-bit register, 0 uses the sign-extended low 16 bits.
  - The chosen value is shifted left by the count in bits 10:9.
- R3: The base is `pc_in` when `mode_reg` is 6'b111011. Otherwise it is the address register numbered by `mode_reg[2:0]`.
- R4: In full format (bit 8 = 1), bit 7 set forces the base to zero and bit 6 set forces the index to zero.
- R5: Bits 5:4 give the base displacement size:
  - 0 or 1: no displacement.
  - 2: one further word, sign-extended.
  - 3: two further words, upper word first.
- R6: The selector is {bit 6, bits 2:0}. Selectors 0 and 8 give base + base displacement + index, with no memory read.
- R7: Selectors 1, 2, 3, 9, 10 and 11 read a long at base + base displacement + index. The address is the data read + the outer displacement.
- R8: Selectors 5, 6 and 7 read a long at base + base displacement. The address is the data read + index + outer displacement.
- R9: The outer displacement is fetched after the base displacement. Selector bits 1:0 = 2 give one sign-extended word, 3 gives a long (upper word first), and 1 gives none.
- R10: `ext_len` is 2 + 2 × the number of further instruction words consumed.
- R11: Full-format selectors 4 and 12 to 15 raise `illegal`. With them the result is address 0 and length 2, and no word or read is requested.
- R12: A bus error on the word stream or on the indirect read ends the calculation. It raises `aborted`, gives address 0, and issues no further request.
- R13: Each request stays high until its valid or error input is seen. `done` lasts exactly one cycle. Word and read requests never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (sampled in idle) |
| ext_word | input | 16 | Extension word |
| mode_reg | input | 6 | Mode (5:3) and register (2:0) field |
| pc_in | input | DW | PC value at the extension word |
| dreg_flat | input | NREG*DW | Data registers, register i at bits i*DW +: DW |
| areg_flat | input | NREG*DW | Address registers, same packing |
| iw_req | output | 1 | Request for the next instruction word |
| iw_valid | input | 1 | Instruction word accepted |
| iw_err | input | 1 | Bus error on instruction word |
| iw_data | input | 16 | Instruction word |
| rd_req | output | 1 | Indirect long read request |
| rd_addr | output | DW | Indirect read address |
| rd_valid | input | 1 | Read data valid |
| rd_err | input | 1 | Bus error on read |
| rd_data | input | DW | Read data |
| done | output | 1 | One-cycle result strobe |
| ea | output | DW | Effective address (valid with done) |
| ext_len | output | 4 | Extension bytes consumed |
| illegal | output | 1 | Illegal selector (valid with done) |
| aborted | output | 1 | Bus error abort (valid with done) |

## Verification
The brief format is tried twice. One run uses a negative word-size data index with a negative byte displacement on an address-register base. The other uses a long address index on the PC base. Together they separate register-file choice, index sizing, scaling and base choice.

The full format is driven through several cases. Each displacement size is used for the base displacement. Both suppression bits are tried, and every selector group is covered: no indirection, pre-indexed with and without suppressed index, and post-indexed. Pre-indexed and post-indexed runs use a non-zero index, so the read address and the final sum show which of the two the block applied.

Illegal selectors, bus errors on a word and on the read, and a stalled word stream check the early exits and the request holding.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BD_HI,
        ST_BD_LO,
        ST_OD_HI,
        ST_OD_LO,
        ST_IND,
        ST_DONE
    } ea_state_e;

    localparam int XW = 16;

    function automatic logic [3:0] sel_of(input logic [XW-1:0] e);
        return {e[6], e[2:0]};
    endfunction

    // full-format word with a reserved selector
    function automatic logic is_illegal(input logic [XW-1:0] e);
        logic [3:0] s;
        s = sel_of(e);
        return e[8] && ((s == 4'd4) || (s[3:2] == 2'b11));
    endfunction

    // memory indirection requested (full format, selector low bits non-zero)
    function automatic logic is_indirect(input logic [XW-1:0] e);
        return e[8] && (e[2:0] != 3'd0);
    endfunction

    function automatic ea_state_e after_bd(input logic [XW-1:0] e);
        ea_state_e n;
        case (e[1:0])
            2'd2:    n = ST_OD_LO;
            2'd3:    n = ST_OD_HI;
            default: n = (e[2:0] != 3'd0) ? ST_IND : ST_DONE;
        endcase
        return n;
    endfunction

    function automatic ea_state_e after_start(input logic [XW-1:0] e);
        ea_state_e n;
        case (e[5:4])
            2'd2:    n = ST_BD_LO;
            2'd3:    n = ST_BD_HI;
            default: n = after_bd(e);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/idx_ea_operand.sv
module idx_ea_operand #(
    parameter int DW   = 32,
    parameter int NREG = 8
) (
    input  logic [15:0]        ext_word,
    input  logic [5:0]         mode_reg,
    input  logic [DW-1:0]      pc_in,
    input  logic [NREG*DW-1:0] dreg_flat,
    input  logic [NREG*DW-1:0] areg_flat,
    output logic [DW-1:0]      base_val,
    output logic [DW-1:0]      index_val
);
    localparam int RW = $clog2(NREG);
    localparam logic [5:0] PC_REL = 6'b111011;

    logic [DW-1:0] dr [NREG];
    logic [DW-1:0] ar [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign dr[g] = dreg_flat[g*DW +: DW];
        assign ar[g] = areg_flat[g*DW +: DW];
    end

    logic [RW-1:0] inum;
    logic [RW-1:0] bnum;
    logic [DW-1:0] raw;
    logic [DW-1:0] sized;

    always_comb begin
        inum  = RW'(ext_word[14:12]);
        bnum  = RW'(mode_reg[2:0]);
        raw   = ext_word[15] ? ar[inum] : dr[inum];
        sized = ext_word[11] ? raw : {{(DW-16){raw[15]}}, raw[15:0]};
        index_val = sized << ext_word[10:9];
        base_val  = (mode_reg == PC_REL) ? pc_in : ar[bnum];
    end

endmodule

// File: rtl/idx_ea_fsm.sv
module idx_ea_fsm
    import idx_ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] ext_in,
    input  logic [15:0] ext_q,
    input  logic        iw_valid,
    input  logic        iw_err,
    input  logic        rd_valid,
    input  logic        rd_err,
    output logic        iw_req,
    output logic        rd_req,
    output logic        done,
    output logic        ld_start,
    output logic        ld_bd_hi,
    output logic        ld_bd_lo,
    output logic        ld_od_hi,
    output logic        ld_od_lo,
    output logic        ld_ind,
    output logic        abort_set
);
    ea_state_e st, nxt;
    logic      w_ok;

    assign w_ok = iw_valid && !iw_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (start) begin
                if (!ext_in[8] || is_illegal(ext_in)) nxt = ST_DONE;
                else                                  nxt = after_start(ext_in);
            end
            ST_BD_HI: if (iw_err) nxt = ST_DONE; else if (iw_valid) nxt = ST_BD_LO;
            ST_BD_LO: if (iw_err) nxt = ST_DONE; else if (iw_valid) nxt = after_bd(ext_q);
            ST_OD_HI: if (iw_err) nxt = ST_DONE; else if (iw_valid) nxt = ST_OD_LO;
            ST_OD_LO: if (iw_err) nxt = ST_DONE; else if (iw_valid) nxt = ST_IND;
            ST_IND:   if (rd_err || rd_valid) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        iw_req    = 1'b0;
        rd_req    = 1'b0;
        done      = 1'b0;
        ld_start  = 1'b0;
        ld_bd_hi  = 1'b0;
        ld_bd_lo  = 1'b0;
        ld_od_hi  = 1'b0;
        ld_od_lo  = 1'b0;
        ld_ind    = 1'b0;
        abort_set = 1'b0;
        unique case (st)
            ST_IDLE:  ld_start = start;
            ST_BD_HI: begin iw_req = 1'b1; ld_bd_hi = w_ok; abort_set = iw_err; end
            ST_BD_LO: begin iw_req = 1'b1; ld_bd_lo = w_ok; abort_set = iw_err; end
            ST_OD_HI: begin iw_req = 1'b1; ld_od_hi = w_ok; abort_set = iw_err; end
            ST_OD_LO: begin iw_req = 1'b1; ld_od_lo = w_ok; abort_set = iw_err; end
            ST_IND:   begin rd_req = 1'b1; ld_ind = rd_valid && !rd_err; abort_set = rd_err; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/idx_ea_dpath.sv
module idx_ea_dpath
    import idx_ea_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_start,
    input  logic          ld_bd_hi,
    input  logic          ld_bd_lo,
    input  logic          ld_od_hi,
    input  logic          ld_od_lo,
    input  logic          ld_ind,
    input  logic          abort_set,
    input  logic [15:0]   ext_in,
    input  logic [15:0]   iw_data,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] index_val,
    output logic [15:0]   ext_q,
    output logic [DW-1:0] rd_addr,
    output logic [DW-1:0] ea,
    output logic [3:0]    len_q,
    output logic          illegal_q,
    output logic          aborted_q
);
    logic [DW-1:0] base_q, idx_q, bd_q, od_q, ind_q;
    logic [15:0]   hi_q;
    logic          full;
    logic [DW-1:0] w_sx;
    logic [DW-1:0] w_long;

    assign full   = ext_in[8];
    assign w_sx   = {{(DW-16){iw_data[15]}}, iw_data};
    assign w_long = DW'({hi_q, iw_data});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q     <= '0;
            base_q    <= '0;
            idx_q     <= '0;
            bd_q      <= '0;
            od_q      <= '0;
            ind_q     <= '0;
            hi_q      <= '0;
            len_q     <= '0;
            illegal_q <= 1'b0;
            aborted_q <= 1'b0;
        end else begin
            if (ld_start) begin
                ext_q     <= ext_in;
                base_q    <= (full && ext_in[7]) ? '0 : base_val;
                idx_q     <= (full && ext_in[6]) ? '0 : index_val;
                bd_q      <= full ? '0 : {{(DW-8){ext_in[7]}}, ext_in[7:0]};
                od_q      <= '0;
                ind_q     <= '0;
                len_q     <= 4'd2;
                illegal_q <= is_illegal(ext_in);
                aborted_q <= 1'b0;
            end
            if (ld_bd_hi || ld_od_hi) begin
                hi_q  <= iw_data;
                len_q <= len_q + 4'd2;
            end
            if (ld_bd_lo) begin
                bd_q  <= (ext_q[5:4] == 2'd3) ? w_long : w_sx;
                len_q <= len_q + 4'd2;
            end
            if (ld_od_lo) begin
                od_q  <= (ext_q[1:0] == 2'd3) ? w_long : w_sx;
                len_q <= len_q + 4'd2;
            end
            if (ld_ind)    ind_q     <= rd_data;
            if (abort_set) aborted_q <= 1'b1;
        end
    end

    logic post;
    assign post = ext_q[2];

    always_comb begin
        rd_addr = base_q + bd_q + (post ? '0 : idx_q);
        if (aborted_q || illegal_q)
            ea = '0;
        else if (is_indirect(ext_q))
            ea = ind_q + od_q + (post ? idx_q : '0);
        else
            ea = base_q + bd_q + idx_q;
    end

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc #(
    parameter int DW   = 32,
    parameter int NREG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [15:0]        ext_word,
    input  logic [5:0]         mode_reg,
    input  logic [DW-1:0]      pc_in,
    input  logic [NREG*DW-1:0] dreg_flat,
    input  logic [NREG*DW-1:0] areg_flat,
    output logic               iw_req,
    input  logic               iw_valid,
    input  logic               iw_err,
    input  logic [15:0]        iw_data,
    output logic               rd_req,
    output logic [DW-1:0]      rd_addr,
    input  logic               rd_valid,
    input  logic               rd_err,
    input  logic [DW-1:0]      rd_data,
    output logic               done,
    output logic [DW-1:0]      ea,
    output logic [3:0]         ext_len,
    output logic               illegal,
    output logic               aborted
);
    logic [DW-1:0] base_val, index_val;
    logic [15:0]   ext_q;
    logic          ld_start, ld_bd_hi, ld_bd_lo, ld_od_hi, ld_od_lo, ld_ind, abort_set;
    logic          illegal_q, aborted_q;

    idx_ea_operand #(.DW(DW), .NREG(NREG)) u_operand (
        .ext_word  (ext_word),
        .mode_reg  (mode_reg),
        .pc_in     (pc_in),
        .dreg_flat (dreg_flat),
        .areg_flat (areg_flat),
        .base_val  (base_val),
        .index_val (index_val)
    );

    idx_ea_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ext_in    (ext_word),
        .ext_q     (ext_q),
        .iw_valid  (iw_valid),
        .iw_err    (iw_err),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err),
        .iw_req    (iw_req),
        .rd_req    (rd_req),
        .done      (done),
        .ld_start  (ld_start),
        .ld_bd_hi  (ld_bd_hi),
        .ld_bd_lo  (ld_bd_lo),
        .ld_od_hi  (ld_od_hi),
        .ld_od_lo  (ld_od_lo),
        .ld_ind    (ld_ind),
        .abort_set (abort_set)
    );

    idx_ea_dpath #(.DW(DW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_start  (ld_start),
        .ld_bd_hi  (ld_bd_hi),
        .ld_bd_lo  (ld_bd_lo),
        .ld_od_hi  (ld_od_hi),
        .ld_od_lo  (ld_od_lo),
        .ld_ind    (ld_ind),
        .abort_set (abort_set),
        .ext_in    (ext_word),
        .iw_data   (iw_data),
        .rd_data   (rd_data),
        .base_val  (base_val),
        .index_val (index_val),
        .ext_q     (ext_q),
        .rd_addr   (rd_addr),
        .ea        (ea),
        .len_q     (ext_len),
        .illegal_q (illegal_q),
        .aborted_q (aborted_q)
    );

    assign illegal = done && illegal_q;
    assign aborted = done && aborted_q;

endmodule

// File: rtl/idx_ea_checker.sv
module idx_ea_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iw_req,
    input logic          iw_valid,
    input logic          iw_err,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          rd_err,
    input logic          done,
    input logic [DW-1:0] ea,
    input logic [3:0]    ext_len,
    input logic          illegal,
    input logic          aborted
);
    assert_iw_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_req && !iw_valid && !iw_err) |=> iw_req);

    assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !rd_err) |=> rd_req);

    assert_no_overlap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(iw_req && rd_req));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_illegal_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (ext_len == 4'd2 && ea == '0));

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> $past(!iw_req && !rd_req));

    assert_abort_ea_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && aborted) |-> (ea == '0 && !illegal));

    assert_len_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ext_len[0] && ext_len >= 4'd2 && ext_len <= 4'd10));

    assert_abort_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_req && iw_err) |=> !iw_req);

endmodule

bind idx_ea_calc idx_ea_checker #(.DW(DW)) u_chk (.*);

// File: tb/idx_ea_calc_bench.sv
`timescale 1ns/1ps
module idx_ea_calc_bench;
    localparam int DW = 32;
    localparam int NREG = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [15:0]        ext_word = '0;
    logic [5:0]         mode_reg = '0;
    logic [DW-1:0]      pc_in = 32'h0004_2000;
    logic [NREG*DW-1:0] dreg_flat;
    logic [NREG*DW-1:0] areg_flat;
    logic               iw_req, iw_valid, iw_err;
    logic [15:0]        iw_data;
    logic               rd_req, rd_valid, rd_err;
    logic [DW-1:0]      rd_addr, rd_data;
    logic               done, illegal, aborted;
    logic [DW-1:0]      ea;
    logic [3:0]         ext_len;

    always #10 clk = ~clk;

    idx_ea_calc #(.DW(DW), .NREG(NREG)) u_idx_ea_calc (.*);

    logic [31:0] dr [NREG];
    logic [31:0] ar [NREG];
    logic [15:0] wq [8];
    int stall_n = 0;
    int err_idx = 99;
    logic mem_err_en = 1'b0;
    int base_taken = 0;

    int iw_taken = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    logic [31:0] last_rd = '0;

    int checks = 0;
    int errors = 0;

    for (genvar g = 0; g < NREG; g++) begin : g_pack
        assign dreg_flat[g*DW +: DW] = dr[g];
        assign areg_flat[g*DW +: DW] = ar[g];
    end

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h0F0F_3C3C;
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

    // R2 index rule, from the requirement text
    function automatic logic [31:0] idx_of(input logic [15:0] e);
        logic [31:0] v;
        v = e[15] ? ar[e[14:12]] : dr[e[14:12]];
        if (!e[11]) v = sx16(v[15:0]);
        return v << e[10:9];
    endfunction

    // word-stream and read responders
    always @(posedge clk) begin
        if (iw_req && (iw_valid || iw_err)) begin
            iw_taken <= iw_taken + 1;
            wcnt <= 0;
        end else if (iw_req) begin
            wcnt <= wcnt + 1;
        end
        if (rd_req && (rd_valid || rd_err)) begin
            rd_cnt  <= rd_cnt + 1;
            last_rd <= rd_addr;
        end
    end

    always @(negedge clk) begin
        int k;
        k = iw_taken - base_taken;
        iw_data  = wq[k & 7];
        iw_valid = iw_req && (wcnt >= stall_n) && (k != err_idx);
        iw_err   = iw_req && (wcnt >= stall_n) && (k == err_idx);
        rd_data  = mem_fn(rd_addr);
        rd_valid = rd_req && !mem_err_en;
        rd_err   = rd_req && mem_err_en;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] r_ea;
    logic [3:0]  r_len;
    logic        r_ill, r_abt;
    int          r_words, r_reads;

    task automatic run_op(input logic [15:0] e, input logic [5:0] mr);
        int t;
        int rd0;
        @(negedge clk);
        base_taken = iw_taken;
        rd0 = rd_cnt;
        ext_word = e;
        mode_reg = mr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk("R13 done seen", {31'd0, done}, 32'd1);
        r_ea = ea; r_len = ext_len; r_ill = illegal; r_abt = aborted;
        r_words = iw_taken - base_taken;
        r_reads = rd_cnt - rd0;
        @(negedge clk);
        chk("R13 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] exp_ea, input int exp_len,
                             input int exp_reads, input logic [31:0] exp_rd);
        chk({tag, " ea"}, r_ea, exp_ea);
        chk({tag, " R10 len"}, {28'd0, r_len}, exp_len);
        chk({tag, " R10 words"}, r_words, (exp_len - 2) / 2);
        chk({tag, " reads"}, r_reads, exp_reads);
        if (exp_reads > 0) chk({tag, " rd_addr"}, last_rd, exp_rd);
        chk({tag, " illegal"}, {31'd0, r_ill}, 32'd0);
        chk({tag, " aborted"}, {31'd0, r_abt}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R13 reset done", {31'd0, done}, 32'd0);
        chk("R13 reset iw_req", {31'd0, iw_req}, 32'd0);
        chk("R13 reset rd_req", {31'd0, rd_req}, 32'd0);
    endtask

    task automatic t_brief_dreg;
        run_op(16'h34FC, 6'b110010);
        expect_ok("R1 R2 brief D-word", ar[2] + 32'hFFFF_FFFC + idx_of(16'h34FC), 2, 0, 0);
        chk("R2 sext index", idx_of(16'h34FC), 32'hFFFF_C000);
    endtask

    task automatic t_brief_pc;
        run_op(16'hD810, 6'b111011);
        expect_ok("R1 R3 brief pc", pc_in + 32'h10 + ar[5], 2, 0, 0);
    endtask

    task automatic t_full_bd_word;
        wq[0] = 16'h8000;
        run_op(16'h1F20, 6'b110001);
        expect_ok("R5 R6 bd word", ar[1] + 32'hFFFF_8000 + (dr[1] << 3), 4, 0, 0);
    endtask

    task automatic t_full_suppress;
        wq[0] = 16'h1234; wq[1] = 16'h5678;
        run_op(16'h01F0, 6'b110100);
        expect_ok("R4 R5 R6 suppress long", 32'h1234_5678, 6, 0, 0);
    endtask

    task automatic t_pre_null;
        logic [31:0] a;
        a = ar[6] + idx_of(16'hC311);
        run_op(16'hC311, 6'b110110);
        expect_ok("R7 pre null", mem_fn(a), 2, 1, a);
    endtask

    task automatic t_pre_long_od;
        logic [31:0] a;
        wq[0] = 16'h0040; wq[1] = 16'h0001; wq[2] = 16'h0000;
        a = ar[0] + 32'h40 + dr[2];
        run_op(16'h2923, 6'b110000);
        expect_ok("R7 R9 pre long od", mem_fn(a) + 32'h0001_0000, 8, 1, a);
    endtask

    task automatic t_post_word_od;
        logic [31:0] a;
        wq[0] = 16'h0000; wq[1] = 16'h2000; wq[2] = 16'hFFF0;
        a = ar[7] + 32'h2000;
        run_op(16'h3336, 6'b110111);
        expect_ok("R8 R9 post word od", mem_fn(a) + idx_of(16'h3336) + 32'hFFFF_FFF0, 8, 1, a);
    endtask

    task automatic t_pre_is;
        logic [31:0] a;
        wq[0] = 16'h0100; wq[1] = 16'h0008;
        a = pc_in + 32'h100;
        run_op(16'h1162, 6'b111011);
        expect_ok("R7 R4 sel10", mem_fn(a) + 32'h8, 6, 1, a);
    endtask

    task automatic t_sel11;
        logic [31:0] a;
        wq[0] = 16'h0000; wq[1] = 16'h0010;
        a = ar[3];
        run_op(16'h0143, 6'b110011);
        expect_ok("R7 R9 sel11", mem_fn(a) + 32'h10, 6, 1, a);
    endtask

    task automatic t_post_long;
        logic [31:0] a;
        wq[0] = 16'h0000; wq[1] = 16'h0100;
        a = ar[5];
        run_op(16'h9D07, 6'b110101);
        expect_ok("R8 sel7", mem_fn(a) + (ar[1] << 2) + 32'h100, 6, 1, a);
    endtask

    task automatic t_illegal(input logic [15:0] e);
        run_op(e, 6'b110000);
        chk("R11 illegal flag", {31'd0, r_ill}, 32'd1);
        chk("R11 ea zero", r_ea, 32'd0);
        chk("R11 len", {28'd0, r_len}, 32'd2);
        chk("R11 no words", r_words, 0);
        chk("R11 no reads", r_reads, 0);
    endtask

    task automatic t_abort_word;
        wq[0] = 16'h1111; wq[1] = 16'h2222;
        err_idx = 1;
        run_op(16'h0133, 6'b110000);
        err_idx = 99;
        chk("R12 word abort flag", {31'd0, r_abt}, 32'd1);
        chk("R12 word abort ea", r_ea, 32'd0);
        chk("R12 word abort words", r_words, 2);
        chk("R12 word abort no read", r_reads, 0);
    endtask

    task automatic t_abort_read;
        mem_err_en = 1'b1;
        run_op(16'h0111, 6'b110010);
        mem_err_en = 1'b0;
        chk("R12 read abort flag", {31'd0, r_abt}, 32'd1);
        chk("R12 read abort ea", r_ea, 32'd0);
        chk("R12 read abort reads", r_reads, 1);
    endtask

    task automatic t_stall;
        logic [31:0] a;
        stall_n = 3;
        wq[0] = 16'h0040; wq[1] = 16'h0001; wq[2] = 16'h0000;
        a = ar[0] + 32'h40 + dr[2];
        run_op(16'h2923, 6'b110000);
        stall_n = 0;
        expect_ok("R13 stalled stream", mem_fn(a) + 32'h0001_0000, 8, 1, a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            dr[i] = 32'h0101_0000 * i + 32'h0000_0111 * (i + 1);
            ar[i] = 32'h0010_0000 * (i + 1) + 32'h0000_0100 * i;
        end
        dr[3] = 32'h1234_F000;
        for (int i = 0; i < 8; i++) wq[i] = '0;
        iw_valid = 1'b0; iw_err = 1'b0; iw_data = '0;
        rd_valid = 1'b0; rd_err = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_brief_dreg;
        t_brief_pc;
        t_full_bd_word;
        t_full_suppress;
        t_pre_null;
        t_pre_long_od;
        t_post_word_od;
        t_pre_is;
        t_sel11;
        t_post_long;
        t_illegal(16'h0104);
        t_illegal(16'h0144);
        t_illegal(16'h0174);
        t_abort_word;
        t_abort_read;
        t_stall;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule